// File: doc/BRIEF.md
# Alarm Indicator and Cutoff Controller

This block turns two alarm request lines, one for major and one for minor severity, into a three-colour node status indicator, a latched indicator for major-alarm history, and drive enables for a pair of external alarm relays. An operator has two momentary push-buttons. One of them extinguishes the history indicator. The other silences the relays until a fresh alarm shows up.

The alarm lines and the buttons are asynchronous to the block clock, and each passes through a synchronizer. Each button also passes through a debouncer and acts once per press, on the press edge. Relay silencing is held in a cutoff flag. A rising edge on either alarm line clears that flag, and this includes a rise from minor-only to major. While the flag is clear, the relays follow the alarm levels.

Top module: `alarm_panel_ctrl`

## Requirements
- R1: While reset is asserted, and after its release with both alarm lines low, only the green status LED is lit, the history LED is off and both relay enables are low.
- R2: The red status LED is lit exactly while the major alarm line is high, whatever the level of the minor line.
- R3: The yellow status LED is lit exactly while the minor line is high and the major line is low.
- R4: The green status LED is lit exactly while both alarm lines are low. Exactly one status LED is lit at any time.
- R5: The history LED lights once the major line has been high. It stays lit after the major line falls.
- R6: A clear-button press turns the history LED off. If the major line is still high, the LED lights again one cycle later.
- R7: While no cutoff is in force, relay_major_o follows the major line and relay_minor_o follows the minor line.
- R8: A cutoff-button press drives both relay enables low while the alarm lines stay high.
- R9: A rising edge on either alarm line ends a cutoff, so the relays again follow the alarm levels. A rise of the major line while the minor line is already high counts as such an edge.
- R10: A button acts only after its synchronized level has differed from its debounced state for DEBOUNCE_HOLD consecutive cycles. A shorter pulse has no effect. A release does nothing.
- R11: A change on an alarm line shows on the status LEDs and the relays at the (SYNC_STAGES+1)-th rising clock edge after the change. The history LED follows one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| major_req_i | input | 1 | Major alarm request level (asynchronous) |
| minor_req_i | input | 1 | Minor alarm request level (asynchronous) |
| clear_btn_i | input | 1 | Raw history-clear push-button, high when pressed |
| cutoff_btn_i | input | 1 | Raw relay-cutoff push-button, high when pressed |
| led_red_o | output | 1 | Status LED red: major alarm active |
| led_yellow_o | output | 1 | Status LED yellow: only minor alarm active |
| led_green_o | output | 1 | Status LED green: no alarm |
| led_hist_o | output | 1 | Major-alarm history LED |
| relay_major_o | output | 1 | Major alarm relay enable |
| relay_minor_o | output | 1 | Minor alarm relay enable |

## Verification
The bench builds the block with SYNC_STAGES=2 and DEBOUNCE_HOLD=4. With these values a valid press settles in a handful of cycles, so many presses fit in one short run. A two-cycle glitch falls below the hold threshold and must be ignored. The short synchronizer makes it practical to check the exact edge at which the LEDs and relays change. The run also covers a clear while the major alarm is still up, a cutoff with both alarms present, and a minor-to-major escalation that ends the cutoff.

// File: rtl/alarm_panel_pkg.sv
package alarm_panel_pkg;

  typedef struct packed {
    logic major;
    logic minor;
  } alarm_lvl_t;

  typedef enum logic [1:0] {
    COL_GREEN  = 2'd0,
    COL_YELLOW = 2'd1,
    COL_RED    = 2'd2
  } colour_e;

  localparam int NUM_BTN = 2;
  localparam int BTN_CLEAR  = 0;
  localparam int BTN_CUTOFF = 1;

endpackage

// File: rtl/apc_sync.sv
module apc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // STAGES must be 2 or more
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/apc_debounce.sv
module apc_debounce #(
  parameter int SYNC_STAGES   = 2,
  parameter int DEBOUNCE_HOLD = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_raw_i,
  output logic press_o
);
  localparam int CW = $clog2(DEBOUNCE_HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_HOLD - 1);

  logic          btn_s;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          stable_q, stable_d;
  logic          press_q, press_d;

  apc_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (btn_raw_i),
    .q_o    (btn_s)
  );

  always_comb begin
    cnt_d    = '0;
    stable_d = stable_q;
    press_d  = 1'b0;
    if (btn_s != stable_q) begin
      if (cnt_q == LAST) begin
        stable_d = btn_s;
        press_d  = btn_s;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
      press_q  <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      stable_q <= stable_d;
      press_q  <= press_d;
    end
  end

  assign press_o = press_q;

  // R10: one action per press
  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_q |=> !press_q);
  // R10: a press is only reported with the debounced state high
  assert_press_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_q |-> stable_q);
  // R10: debounced state moves only after a full hold window
  assert_hold_window_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stable_q != $past(stable_q)) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/apc_status.sv
module apc_status
  import alarm_panel_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  alarm_lvl_t alarm_s_i,
  input  logic       clr_press_i,
  output alarm_lvl_t alarm_l_o,
  output logic       new_alarm_o,
  output logic       led_red_o,
  output logic       led_yellow_o,
  output logic       led_green_o,
  output logic       led_hist_o
);
  alarm_lvl_t lvl_q, lvl_d;
  logic       hist_q, hist_d, hist_en;
  colour_e    colour;

  always_comb begin
    lvl_d   = alarm_s_i;
    hist_en = clr_press_i | (lvl_q.major & ~hist_q);
    hist_d  = ~clr_press_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= 1'b0;
    else if (hist_en) hist_q <= hist_d;
  end

  always_comb begin
    if (lvl_q.major)      colour = COL_RED;
    else if (lvl_q.minor) colour = COL_YELLOW;
    else                  colour = COL_GREEN;
  end

  assign led_red_o    = (colour == COL_RED);
  assign led_yellow_o = (colour == COL_YELLOW);
  assign led_green_o  = (colour == COL_GREEN);
  assign led_hist_o   = hist_q;
  assign alarm_l_o    = lvl_q;
  assign new_alarm_o  = (alarm_s_i.major & ~lvl_q.major) | (alarm_s_i.minor & ~lvl_q.minor);

  // R4: exactly one status colour
  assert_one_colour_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({led_red_o, led_yellow_o, led_green_o}) == 1);
  // R5: history sets after a major level
  assert_hist_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q.major && !clr_press_i) |=> led_hist_o);
  // R5: history holds without a clear
  assert_hist_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (led_hist_o && !clr_press_i) |=> led_hist_o);
  // R6: a clear press extinguishes history
  assert_hist_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_press_i |=> !led_hist_o);

endmodule

// File: rtl/apc_relay.sv
module apc_relay
  import alarm_panel_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  alarm_lvl_t alarm_l_i,
  input  logic       new_alarm_i,
  input  logic       cut_press_i,
  output logic       relay_major_o,
  output logic       relay_minor_o
);
  logic cut_q, cut_d, cut_en;

  always_comb begin
    cut_en = new_alarm_i | cut_press_i;
    cut_d  = ~new_alarm_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cut_q <= 1'b0;
    else if (cut_en) cut_q <= cut_d;
  end

  assign relay_major_o = alarm_l_i.major & ~cut_q;
  assign relay_minor_o = alarm_l_i.minor & ~cut_q;

  // R8: a cutoff silences both relays
  assert_cutoff_silences_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cut_press_i && !new_alarm_i) |=> (!relay_major_o && !relay_minor_o));
  // R9: a new alarm edge restores relays to the alarm levels
  assert_new_alarm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_alarm_i |=> ((relay_major_o == alarm_l_i.major) && (relay_minor_o == alarm_l_i.minor)));
  // R7: relays stay silent without a new edge once cut off
  assert_cut_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!relay_major_o && !relay_minor_o && alarm_l_i.major && !new_alarm_i) |=> !relay_major_o);

endmodule

// File: rtl/alarm_panel_ctrl.sv
module alarm_panel_ctrl
  import alarm_panel_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int DEBOUNCE_HOLD = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic major_req_i,
  input  logic minor_req_i,
  input  logic clear_btn_i,
  input  logic cutoff_btn_i,
  output logic led_red_o,
  output logic led_yellow_o,
  output logic led_green_o,
  output logic led_hist_o,
  output logic relay_major_o,
  output logic relay_minor_o
);
  logic [1:0]         rst_pipe_q;
  logic               rst_n_int;
  logic [NUM_BTN-1:0] btn_raw;
  logic [NUM_BTN-1:0] btn_press;
  alarm_lvl_t         alarm_raw, alarm_s, alarm_l;
  logic               new_alarm;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  assign btn_raw[BTN_CLEAR]  = clear_btn_i;
  assign btn_raw[BTN_CUTOFF] = cutoff_btn_i;

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    apc_debounce #(
      .SYNC_STAGES   (SYNC_STAGES),
      .DEBOUNCE_HOLD (DEBOUNCE_HOLD)
    ) u_deb (
      .clk_i     (clk_i),
      .rst_ni    (rst_n_int),
      .btn_raw_i (btn_raw[b]),
      .press_o   (btn_press[b])
    );
  end

  assign alarm_raw.major = major_req_i;
  assign alarm_raw.minor = minor_req_i;

  apc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_alarm_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .d_i    (alarm_raw),
    .q_o    (alarm_s)
  );

  apc_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .alarm_s_i    (alarm_s),
    .clr_press_i  (btn_press[BTN_CLEAR]),
    .alarm_l_o    (alarm_l),
    .new_alarm_o  (new_alarm),
    .led_red_o    (led_red_o),
    .led_yellow_o (led_yellow_o),
    .led_green_o  (led_green_o),
    .led_hist_o   (led_hist_o)
  );

  apc_relay u_relay (
    .clk_i         (clk_i),
    .rst_ni        (rst_n_int),
    .alarm_l_i     (alarm_l),
    .new_alarm_i   (new_alarm),
    .cut_press_i   (btn_press[BTN_CUTOFF]),
    .relay_major_o (relay_major_o),
    .relay_minor_o (relay_minor_o)
  );

  // R2: red follows the synchronized major level one edge later
  assert_red_tracks_R2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    alarm_s.major |=> led_red_o);
  // R1: relays never energise without an alarm level
  assert_relay_needs_alarm_R1: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (relay_major_o |-> led_red_o) and (relay_minor_o |-> !led_green_o));

endmodule

// File: tb/alarm_panel_ctrl_tb_top.sv
module alarm_panel_ctrl_tb_top;

  logic clk;
  logic rst_n;
  logic major_req, minor_req, clear_btn, cutoff_btn;
  logic led_red, led_yellow, led_green, led_hist, relay_major, relay_minor;

  int total_checks = 0;
  int bad_checks   = 0;
  bit done         = 1'b0;

  typedef struct {
    logic [5:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  alarm_panel_ctrl #(.SYNC_STAGES(2), .DEBOUNCE_HOLD(4)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .major_req_i   (major_req),
    .minor_req_i   (minor_req),
    .clear_btn_i   (clear_btn),
    .cutoff_btn_i  (cutoff_btn),
    .led_red_o     (led_red),
    .led_yellow_o  (led_yellow),
    .led_green_o   (led_green),
    .led_hist_o    (led_hist),
    .relay_major_o (relay_major),
    .relay_minor_o (relay_minor)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected vector: {red, yellow, green, hist, relay_major, relay_minor}
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [5:0] exp);
    item_t it;
    @(posedge clk);
    #2;
    it.exp = exp;
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic press(input bit which_cutoff, input int hold);
    if (which_cutoff) cutoff_btn = 1'b1; else clear_btn = 1'b1;
    cyc(hold);
    cutoff_btn = 1'b0;
    clear_btn  = 1'b0;
    cyc(12);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [5:0] act;
        it  = sb_q.pop_front();
        act = {led_red, led_yellow, led_green, led_hist, relay_major, relay_minor};
        total_checks++;
        if (act !== it.exp) begin
          bad_checks++;
          $display("FAIL %s: actual=%b expected=%b", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total_checks++;
      bad_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; major_req = 1'b0; minor_req = 1'b0;
    clear_btn = 1'b0; cutoff_btn = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(4);
    expect_out("R1 idle after reset", 6'b001000);

    // minor only
    minor_req = 1'b1;
    cyc(6);
    expect_out("R3 R7 minor only", 6'b010001);

    // major rises on top of minor: exact edge timing
    @(negedge clk);
    major_req = 1'b1;
    expect_out("R11 edge1 unchanged", 6'b010001);
    expect_out("R11 edge2 unchanged", 6'b010001);
    expect_out("R11 R2 edge3 red", 6'b100011);
    expect_out("R11 R5 edge4 history", 6'b100111);

    // major falls, history stays
    cyc(2);
    major_req = 1'b0;
    cyc(6);
    expect_out("R5 history held", 6'b010101);

    // short glitch on clear
    @(negedge clk);
    clear_btn = 1'b1;
    cyc(2);
    clear_btn = 1'b0;
    cyc(12);
    expect_out("R10 glitch ignored", 6'b010101);

    // proper clear
    press(1'b0, 10);
    expect_out("R6 history cleared", 6'b010001);

    // cutoff with minor active
    press(1'b1, 10);
    expect_out("R8 cutoff minor", 6'b010000);

    // escalation to major ends cutoff
    major_req = 1'b1;
    cyc(6);
    expect_out("R9 escalation reactivates", 6'b100111);

    // cutoff with both alarms
    press(1'b1, 10);
    expect_out("R8 cutoff both", 6'b100100);
    cyc(10);
    expect_out("R10 release no action", 6'b100100);

    // clear while major still active
    press(1'b0, 10);
    expect_out("R6 history relit", 6'b100100);

    // all alarms drop
    major_req = 1'b0;
    minor_req = 1'b0;
    cyc(6);
    expect_out("R4 green no alarm", 6'b001100);

    // new minor edge ends remaining cutoff
    minor_req = 1'b1;
    cyc(6);
    expect_out("R9 minor edge reactivates", 6'b010101);

    // clear and idle
    minor_req = 1'b0;
    press(1'b0, 10);
    expect_out("R4 R6 idle cleared", 6'b001000);

    // no alarm while idle: major rises, relays follow
    major_req = 1'b1;
    cyc(6);
    expect_out("R7 R2 major relay", 6'b100110);

    // reset mid run with alarms asserted
    minor_req = 1'b1;
    cyc(2);
    rst_n = 1'b0;
    expect_out("R1 during reset", 6'b001000);
    cyc(3);
    major_req = 1'b0;
    rst_n = 1'b1;
    cyc(8);
    expect_out("R3 R7 after reset", 6'b010001);

    cyc(4);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

endmodule